// File: doc/BRIEF.md
# Masked Fused Negative Multiply-Add Lane Router

This block sits around a row of 32-bit lanes that each compute a negated product plus an addend. It takes a destination vector (which is also the first source), a second source and a third source. A form select chooses which operand goes to which lane position, so three operand orders are available. The third source can be used lane by lane, or its lowest 32-bit element can be copied to every lane. A per-lane write mask passes or blocks each lane's result. A blocked lane either keeps its old destination value or is forced to zero. All lanes at or above the active vector length are cleared.

The block also reports which rounding mode applies to the operation. An operation-level override is honoured only in one narrow case; in all other cases the global mode is used. A legacy-encoding input turns off masking and broadcast and allows only the two shorter lengths. Illegal requests raise an error and return the destination unchanged.

The lane arithmetic is an exact two's-complement stand-in with an out-of-range flag, suited to exact-valued test operands. Every result is registered, and a new request can be taken on every clock.

Top module: `fnma_lane_router`

## Requirements
- R1: Form code 00 computes, in every written lane, the negated product of the destination and third-source lanes plus the second-source lane.
- R2: Form code 01 computes the negated product of the second-source and destination lanes plus the third-source lane.
- R3: Form code 10 computes the negated product of the second-source and third-source lanes plus the destination lane.
- R4: When src3_mem and bcast are both 1 and legacy_enc is 0, bits 31:0 of the third source feed every lane. When src3_mem is 0, bcast causes no broadcast.
- R5: With mask_en at 1, lane j is written only if lane_mask[j] is 1. A blocked lane keeps its destination value when zero_mode is 0 and reads zero when zero_mode is 1. With mask_en at 0, every active lane is written.
- R6: Length code 00 activates lanes 0..3 (128 bits), 01 activates lanes 0..7 (256 bits) and 10 activates lanes 0..15 (512 bits). Every destination bit above the active length reads zero. Lane j occupies bits 32j+31..32j.
- R7: rnd_out equals rc_override when length code is 10, src3_mem is 0, bcast is 1 and legacy_enc is 0. In every other case it equals rc_global.
- R8: With legacy_enc at 1, lane_mask, mask_en, zero_mode and bcast have no effect, and every active lane is written.
- R9: Length code 11, form code 11, or legacy_enc with length code 10 is illegal. Such a request sets err_out, leaves dst_out equal to dst_in and clears ovf_out.
- R10: ovf_out is the OR of the lane out-of-range flags over the written lanes only. A lane is flagged when its exact result lies outside the signed 32-bit range. The low 32 bits of that result are still stored.
- R11: out_valid rises one clock after in_valid. A request is accepted on every clock. When in_valid is 0, the outputs other than out_valid hold their values.
- R12: A synchronous reset clears out_valid, dst_out, err_out, ovf_out and rnd_out, and it takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| form_sel | input | 2 | Operand order: 00, 01, 10 (11 illegal) |
| len_code | input | 2 | Vector length: 00=128, 01=256, 10=512, 11 illegal |
| legacy_enc | input | 1 | Legacy encoding: no masking, no broadcast, no 512 |
| mask_en | input | 1 | Enable per-lane write mask |
| zero_mode | input | 1 | 1 = zero blocked lanes, 0 = merge |
| lane_mask | input | 16 | Per-lane write enables |
| src3_mem | input | 1 | Third source comes from memory |
| bcast | input | 1 | Broadcast / override bit |
| rc_global | input | 2 | Global rounding mode |
| rc_override | input | 2 | Operation-level rounding mode |
| dst_in | input | 512 | Destination / first source |
| src2_in | input | 512 | Second source |
| src3_in | input | 512 | Third source |
| out_valid | output | 1 | Result valid |
| dst_out | output | 512 | New destination |
| err_out | output | 1 | Illegal request flag |
| ovf_out | output | 1 | OR of written lanes' out-of-range flags |
| rnd_out | output | 2 | Rounding mode selected |

## Verification
All results are due exactly one rising edge after the request: dst_out, err_out, ovf_out and rnd_out together with out_valid. The bench applies each request at a falling edge and compares at the next falling edge. Vectors are applied back to back, so each row's result is checked in the same half-cycle in which the next row is applied, which also confirms one request per clock. An idle cycle after the table checks the hold behaviour. A reset applied together with a request is checked at the following falling edge.

// File: rtl/fnma_pkg.sv
package fnma_pkg;

  typedef enum logic [1:0] {
    ORDER_DS_S2 = 2'b00,  // -(dst*s3)+s2
    ORDER_SD_S3 = 2'b01,  // -(s2*dst)+s3
    ORDER_SS_D  = 2'b10,  // -(s2*s3)+dst
    ORDER_BAD   = 2'b11
  } order_e;

  typedef enum logic [1:0] {
    SPAN_Q   = 2'b00,
    SPAN_H   = 2'b01,
    SPAN_F   = 2'b10,
    SPAN_BAD = 2'b11
  } span_e;

  // number of active lanes for a length code, given the full lane count
  function automatic int unsigned span_lanes(input logic [1:0] code, input int unsigned full);
    case (code)
      2'b00:   return full / 4;
      2'b01:   return full / 2;
      default: return full;
    endcase
  endfunction

endpackage

// File: rtl/fnma_operand_mux.sv
module fnma_operand_mux #(
  parameter int LANE_W = 32,
  parameter int NLANES = 16,
  localparam int VEC_W = LANE_W * NLANES
) (
  input  logic [1:0]       order,
  input  logic             spread,
  input  logic [VEC_W-1:0] dst_v,
  input  logic [VEC_W-1:0] s2_v,
  input  logic [VEC_W-1:0] s3_v,
  output logic [VEC_W-1:0] mul_a,
  output logic [VEC_W-1:0] mul_b,
  output logic [VEC_W-1:0] add_c
);
  import fnma_pkg::*;

  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    logic [LANE_W-1:0] d_l, s2_l, s3_l;
    assign d_l  = dst_v[j*LANE_W +: LANE_W];
    assign s2_l = s2_v[j*LANE_W +: LANE_W];
    // element broadcast takes lane 0 of the third source
    assign s3_l = spread ? s3_v[LANE_W-1:0] : s3_v[j*LANE_W +: LANE_W];

    always_comb begin
      case (order_e'(order))
        ORDER_DS_S2: begin
          mul_a[j*LANE_W +: LANE_W] = d_l;
          mul_b[j*LANE_W +: LANE_W] = s3_l;
          add_c[j*LANE_W +: LANE_W] = s2_l;
        end
        ORDER_SD_S3: begin
          mul_a[j*LANE_W +: LANE_W] = s2_l;
          mul_b[j*LANE_W +: LANE_W] = d_l;
          add_c[j*LANE_W +: LANE_W] = s3_l;
        end
        default: begin
          mul_a[j*LANE_W +: LANE_W] = s2_l;
          mul_b[j*LANE_W +: LANE_W] = s3_l;
          add_c[j*LANE_W +: LANE_W] = d_l;
        end
      endcase
    end
  end

endmodule

// File: rtl/fnma_lane_stub.sv
module fnma_lane_stub #(
  parameter int LANE_W = 32,
  localparam int PW = 2 * LANE_W + 2
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] c,
  output logic [LANE_W-1:0] res,
  output logic              oor
);
  logic signed [PW-1:0] ax, bx, cx, prod, sum;
  logic [PW-LANE_W:0]   hi;

  assign ax   = PW'($signed(a));
  assign bx   = PW'($signed(b));
  assign cx   = PW'($signed(c));
  assign prod = ax * bx;
  assign sum  = cx - prod;
  assign res  = sum[LANE_W-1:0];
  assign hi   = sum[PW-1:LANE_W-1];
  // exact value fits only if the upper bits are a pure sign extension
  assign oor  = !((&hi) || (~|hi));

endmodule

// File: rtl/fnma_writeback.sv
module fnma_writeback #(
  parameter int LANE_W = 32,
  parameter int NLANES = 16,
  localparam int VEC_W = LANE_W * NLANES
) (
  input  logic [VEC_W-1:0]  dst_v,
  input  logic [VEC_W-1:0]  res_v,
  input  logic [NLANES-1:0] oor_v,
  input  logic [NLANES-1:0] live,
  input  logic [NLANES-1:0] wr,
  input  logic              zero_fill,
  output logic [VEC_W-1:0]  out_v,
  output logic              oor_any
);
  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    always_comb begin
      if (!live[j])
        out_v[j*LANE_W +: LANE_W] = '0;
      else if (wr[j])
        out_v[j*LANE_W +: LANE_W] = res_v[j*LANE_W +: LANE_W];
      else if (zero_fill)
        out_v[j*LANE_W +: LANE_W] = '0;
      else
        out_v[j*LANE_W +: LANE_W] = dst_v[j*LANE_W +: LANE_W];
    end
  end

  assign oor_any = |(oor_v & wr);

endmodule

// File: rtl/fnma_lane_router.sv
module fnma_lane_router #(
  parameter int LANE_W = 32,
  parameter int NLANES = 16,
  localparam int VEC_W = LANE_W * NLANES,
  localparam int Q_W   = (NLANES / 4) * LANE_W,
  localparam int CNT_W = $clog2(NLANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        form_sel,
  input  logic [1:0]        len_code,
  input  logic              legacy_enc,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic [NLANES-1:0] lane_mask,
  input  logic              src3_mem,
  input  logic              bcast,
  input  logic [1:0]        rc_global,
  input  logic [1:0]        rc_override,
  input  logic [VEC_W-1:0]  dst_in,
  input  logic [VEC_W-1:0]  src2_in,
  input  logic [VEC_W-1:0]  src3_in,
  output logic              out_valid,
  output logic [VEC_W-1:0]  dst_out,
  output logic              err_out,
  output logic              ovf_out,
  output logic [1:0]        rnd_out
);
  import fnma_pkg::*;

  logic              illegal, spread, use_ovr;
  logic [CNT_W-1:0]  live_cnt;
  logic [NLANES-1:0] live, wr, oor_v;
  logic [VEC_W-1:0]  mul_a, mul_b, add_c, res_v, wb_v;
  logic              oor_any;

  assign illegal  = (span_e'(len_code) == SPAN_BAD) || (order_e'(form_sel) == ORDER_BAD) ||
                    (legacy_enc && span_e'(len_code) == SPAN_F);
  assign spread   = src3_mem && bcast && !legacy_enc;
  assign use_ovr  = !legacy_enc && (span_e'(len_code) == SPAN_F) && !src3_mem && bcast;
  assign live_cnt = CNT_W'(span_lanes(len_code, NLANES));

  for (genvar j = 0; j < NLANES; j++) begin : g_ctl
    assign live[j] = (CNT_W'(j) < live_cnt);
    assign wr[j]   = live[j] && (legacy_enc || !mask_en || lane_mask[j]);
  end

  fnma_operand_mux #(.LANE_W(LANE_W), .NLANES(NLANES)) u_mux (
    .order (form_sel),
    .spread(spread),
    .dst_v (dst_in),
    .s2_v  (src2_in),
    .s3_v  (src3_in),
    .mul_a (mul_a),
    .mul_b (mul_b),
    .add_c (add_c)
  );

  for (genvar j = 0; j < NLANES; j++) begin : g_alu
    fnma_lane_stub #(.LANE_W(LANE_W)) u_lane (
      .a  (mul_a[j*LANE_W +: LANE_W]),
      .b  (mul_b[j*LANE_W +: LANE_W]),
      .c  (add_c[j*LANE_W +: LANE_W]),
      .res(res_v[j*LANE_W +: LANE_W]),
      .oor(oor_v[j])
    );
  end

  fnma_writeback #(.LANE_W(LANE_W), .NLANES(NLANES)) u_wb (
    .dst_v    (dst_in),
    .res_v    (res_v),
    .oor_v    (oor_v),
    .live     (live),
    .wr       (wr),
    .zero_fill(zero_mode && !legacy_enc),
    .out_v    (wb_v),
    .oor_any  (oor_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_out   <= '0;
      err_out   <= 1'b0;
      ovf_out   <= 1'b0;
      rnd_out   <= 2'b00;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rnd_out <= use_ovr ? rc_override : rc_global;
        err_out <= illegal;
        if (illegal) begin
          dst_out <= dst_in;
          ovf_out <= 1'b0;
        end else begin
          dst_out <= wb_v;
          ovf_out <= oor_any;
        end
      end
    end
  end

  // R11: a request yields a valid result on the next clock
  a_r11_valid_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R11: no request, no valid
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R11: held outputs stay put when idle
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dst_out));
  // R9: an illegal length returns the destination untouched
  a_r9_bad_len: assert property (@(posedge clk) disable iff (rst)
    (in_valid && len_code == 2'b11) |=> (err_out && dst_out == $past(dst_in)));
  // R9 / R10: an error never reports an out-of-range lane
  a_r10_no_flag_on_err: assert property (@(posedge clk) disable iff (rst)
    (out_valid && err_out) |-> !ovf_out);
  // R6: short length clears everything above the first quarter
  a_r6_clear_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && len_code == 2'b00 && form_sel != 2'b11) |=> (dst_out[VEC_W-1:Q_W] == '0));
  // R7: a memory third source always uses the global rounding mode
  a_r7_mem_global: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src3_mem) |=> (rnd_out == $past(rc_global)));
  // R7: legacy encoding never takes the override
  a_r7_legacy_global: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy_enc) |=> (rnd_out == $past(rc_global)));

endmodule

// File: tb/tb_fnma_lane_router.sv
module tb_fnma_lane_router;

  localparam int NL = 16;
  localparam int VW = 32 * NL;
  localparam logic [1:0] RC_G = 2'd1;
  localparam logic [1:0] RC_O = 2'd3;

  typedef struct packed {
    logic [1:0]  form;
    logic [1:0]  len;
    logic        leg;
    logic        men;
    logic        zm;
    logic [15:0] msk;
    logic        mem;
    logic        bc;
    logic [31:0] d;
    logic [31:0] s2;
    logic [31:0] s3;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t TBL [NROWS] = '{
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'd2,          32'd3,          32'd5},           // R1
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'hFFFF_FFF9, 32'd4,          32'd11},          // R2
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'd100,        32'hFFFF_FFFD, 32'd6},           // R3
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'd9,          32'd1,          32'd2},           // R6
    '{2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 16'h00A5, 1'b0, 1'b0, 32'd7,          32'd8,          32'd9},           // R5 merge
    '{2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 16'h3C0F, 1'b0, 1'b0, 32'd12,         32'd2,          32'hFFFF_FFF0},  // R5 zero
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 32'd50,         32'd3,          32'd21},          // R4 broadcast
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 32'd4,          32'd6,          32'd10},          // R7 override
    '{2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b1, 32'd3,          32'd5,          32'd40},          // R8 legacy
    '{2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'd1,          32'd2,          32'd3},           // R9 legacy 512
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'd5,          32'd6,          32'd7},           // R9 bad length
    '{2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'd8,          32'd9,          32'd10},          // R9 bad form
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 32'h4000_0000, 32'd1,          32'd4},           // R10 flagged
    '{2'd0, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 32'h4000_0000, 32'd1,          32'd4}            // R10 masked off
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R6";
      4: return "R5";  5: return "R5";  6: return "R4";  7: return "R7";
      8: return "R8";  9: return "R9"; 10: return "R9"; 11: return "R9";
      12: return "R10";
      default: return "R10";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] form_sel = '0, len_code = '0;
  logic legacy_enc = 1'b0, mask_en = 1'b0, zero_mode = 1'b0, src3_mem = 1'b0, bcast = 1'b0;
  logic [NL-1:0] lane_mask = '0;
  logic [1:0] rc_global = RC_G, rc_override = RC_O;
  logic [VW-1:0] dst_in = '0, src2_in = '0, src3_in = '0;
  logic out_valid, err_out, ovf_out;
  logic [VW-1:0] dst_out;
  logic [1:0] rnd_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fnma_lane_router dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel), .len_code(len_code),
    .legacy_enc(legacy_enc), .mask_en(mask_en), .zero_mode(zero_mode), .lane_mask(lane_mask),
    .src3_mem(src3_mem), .bcast(bcast), .rc_global(rc_global), .rc_override(rc_override),
    .dst_in(dst_in), .src2_in(src2_in), .src3_in(src3_in), .out_valid(out_valid),
    .dst_out(dst_out), .err_out(err_out), .ovf_out(ovf_out), .rnd_out(rnd_out)
  );

  function automatic logic [VW-1:0] build(input logic [31:0] seed, input int step);
    logic [VW-1:0] v;
    for (int j = 0; j < NL; j++) v[j*32 +: 32] = seed + 32'(j * step);
    return v;
  endfunction

  task automatic chk(input string req, input string what, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    form_sel = r.form; len_code = r.len; legacy_enc = r.leg; mask_en = r.men;
    zero_mode = r.zm; lane_mask = r.msk; src3_mem = r.mem; bcast = r.bc;
    dst_in = build(r.d, 1); src2_in = build(r.s2, 2); src3_in = build(r.s3, 3);
  endtask

  task automatic model(input row_t r, output logic [VW-1:0] ed, output logic ee,
                       output logic eo, output logic [1:0] er);
    logic [VW-1:0] d, s2, s3;
    logic [31:0] dl, s2l, s3l;
    longint a, b, c, p;
    int nl;
    bit wr;
    d = build(r.d, 1); s2 = build(r.s2, 2); s3 = build(r.s3, 3);
    er = (!r.leg && r.len == 2'd2 && !r.mem && r.bc) ? RC_O : RC_G;
    ed = '0; ee = 1'b0; eo = 1'b0;
    if (r.len == 2'd3 || r.form == 2'd3 || (r.leg && r.len == 2'd2)) begin
      ed = d; ee = 1'b1;
      return;
    end
    nl = (r.len == 2'd0) ? 4 : (r.len == 2'd1) ? 8 : 16;
    for (int j = 0; j < nl; j++) begin
      dl  = d[j*32 +: 32];
      s2l = s2[j*32 +: 32];
      s3l = (r.mem && r.bc && !r.leg) ? s3[31:0] : s3[j*32 +: 32];
      wr  = r.leg || !r.men || r.msk[j];
      if (wr) begin
        case (r.form)
          2'd0: begin a = longint'($signed(dl));  b = longint'($signed(s3l)); c = longint'($signed(s2l)); end
          2'd1: begin a = longint'($signed(s2l)); b = longint'($signed(dl));  c = longint'($signed(s3l)); end
          default: begin a = longint'($signed(s2l)); b = longint'($signed(s3l)); c = longint'($signed(dl)); end
        endcase
        p = c - a * b;
        ed[j*32 +: 32] = p[31:0];
        if (p > 64'sd2147483647 || p < -64'sd2147483648) eo = 1'b1;
      end else if (!r.zm) begin
        ed[j*32 +: 32] = dl;
      end
    end
  endtask

  task automatic check_row(input int i);
    logic [VW-1:0] ed;
    logic ee, eo;
    logic [1:0] er;
    model(TBL[i], ed, ee, eo, er);
    chk("R11", "out_valid", VW'(out_valid), VW'(1'b1));
    chk(tag_of(i), "dst_out", dst_out, ed);
    chk(tag_of(i), "err_out", VW'(err_out), VW'(ee));
    chk(tag_of(i), "ovf_out", VW'(ovf_out), VW'(eo));
    chk((i == 7) ? "R7" : tag_of(i), "rnd_out", VW'(rnd_out), VW'(er));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk("R12", "out_valid", VW'(out_valid), '0);
    chk("R12", "dst_out", dst_out, '0);
    chk("R12", "err_out", VW'(err_out), '0);
    chk("R12", "ovf_out", VW'(ovf_out), '0);
    chk("R12", "rnd_out", VW'(rnd_out), '0);

    // table, back to back: row i checked while row i+1 is applied (R11)
    drive(TBL[0]);
    in_valid = 1'b1;
    for (int i = 1; i <= NROWS; i++) begin
      @(negedge clk);
      check_row(i - 1);
      if (i < NROWS) drive(TBL[i]);
      else in_valid = 1'b0;
    end

    // R11: idle cycle holds outputs and drops valid
    held = dst_out;
    dst_in = '1;
    @(negedge clk);
    chk("R11", "idle out_valid", VW'(out_valid), '0);
    chk("R11", "idle dst_out", dst_out, held);

    // R12: reset wins over a simultaneous request
    drive(TBL[0]);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk("R12", "reset out_valid", VW'(out_valid), '0);
    chk("R12", "reset dst_out", dst_out, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule